// File: doc/BRIEF.md
# Preloadable Timer with Square-Wave Pin Output

This block is an up-counting timer whose width is set by a parameter (16 bits by default, 8 bits as the small variant). Each time the count passes its all-ones value it does not fall to zero. Instead it reloads from a preload register and raises a one-clock overflow pulse. Every overflow flips a toggle flip-flop, so the toggle runs at half the overflow rate. With M = 2^CNT_W and a preload of N, the square wave has frequency f_tick / (2 × (M − N)).

The square wave reaches a port pin through a data bit. When the data bit is low, the pin is forced low. When the data bit is high and the timer runs, the pin follows the toggle. When the data bit is high and the timer is stopped, the pin keeps the last toggle level. A single count-enable input acts as the tick, so any prescaler stays outside the block. Software writes the preload with a one-cycle strobe.

Top module: `pfd_timer`

## Requirements
- R1: After reset the count, the overflow pulse, the toggle and the preload register are all 0 and the timer is stopped. A first run therefore wraps from all-ones back to 0.
- R2: While run_en and cnt_en are both high, the count rises by one per clock. In every other case it holds, except for R8.
- R3: A counting clock that finds the count at all-ones loads the preload value instead of wrapping. ovf_o is high for exactly the clock after each such event and low otherwise.
- R4: The toggle flips on every overflow. With preload N, pad edges are therefore spaced M − N counting ticks apart.
- R5: When port_bit is 0, pad_o is 0, whatever the run state.
- R6: When port_bit is 1 and the timer runs, pad_o equals the toggle level.
- R7: When port_bit is 1 and the timer is stopped, pad_o holds the last toggle level.
- R8: A preload write while run_en is low also loads the count with the written value on the same clock.
- R9: A preload write while run_en is high leaves the count alone and is used at the next overflow. A write that lands on the overflow clock itself supplies the reload value.
- R10: M is 2^CNT_W. CNT_W = 16 gives 65536 and CNT_W = 8 gives 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Timer on when high |
| cnt_en | input | 1 | Count tick, qualifies each counting clock |
| pre_wr | input | 1 | Preload write strobe |
| pre_data | input | CNT_W | Preload write value |
| port_bit | input | 1 | Port data bit gating the pin |
| count_o | output | CNT_W | Current count |
| ovf_o | output | 1 | One-clock overflow pulse |
| pad_o | output | 1 | Pin level |

## Verification
Two events can land on the same clock: a running preload write and a counter overflow. The bench provokes this directly. It loads the count to all-ones while stopped, then asserts run, tick and a write of a new value together, and checks that the count takes the new value and not the old preload. The random phase draws preload writes near the top of the range while the timer runs, which makes these collisions recur. Every cycle is judged against a reference model built from the requirements.

// File: rtl/pfd_timer_pkg.sv
// Package pfd_timer_pkg
// Shared types for the preloadable timer. Assumes no state of its own.
package pfd_timer_pkg;

    // Source currently driving the pin
    typedef enum logic {
        PAD_FORCED_LOW = 1'b0,
        PAD_FROM_WAVE  = 1'b1
    } pad_src_e;

    // Pick the pin source from the port data bit
    function automatic pad_src_e pick_pad_src(input logic data_bit);
        return data_bit ? PAD_FROM_WAVE : PAD_FORCED_LOW;
    endfunction

endpackage

// File: rtl/pfd_preload.sv
// Module pfd_preload
// Holds the reload value. It also presents the value the counter must use
// if an overflow falls in the cycle of a write: the new data wins.
// Assumes: synchronous active-low reset; pre_wr is one clock per write.
module pfd_preload #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_wr,
    input  logic [CNT_W-1:0] pre_data,
    output logic [CNT_W-1:0] pre_q,
    output logic [CNT_W-1:0] reload_val
);

    // Capture written value
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (pre_wr) pre_q <= pre_data;
    end

    // Forward a same-cycle write to the reload path
    always_comb reload_val = pre_wr ? pre_data : pre_q;

endmodule

// File: rtl/pfd_counter.sv
// Module pfd_counter
// Up-counter that reloads instead of wrapping and flags every overflow.
// Assumes: load_now and counting are never both high (the top guarantees
// this, since load_now needs run_en low).
module pfd_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             counting,
    input  logic             load_now,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    // Overflow happens on a counting clock at the top value
    always_comb wrap_o = counting && (count_o == CNT_TOP);

    // Count, reload on overflow, direct load while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)        count_o <= '0;
        else if (load_now) count_o <= load_val;
        else if (wrap_o)   count_o <= reload_val;
        else if (counting) count_o <= count_o + 1'b1;
    end

    // One-clock overflow pulse
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_o <= 1'b0;
        else        ovf_o <= wrap_o;
    end

endmodule

// File: rtl/pfd_wave_out.sv
// Module pfd_wave_out
// Toggle flip-flop driven by overflow, plus the pin select.
// Assumes: wrap only arrives while the timer runs, so the level is frozen
// when the timer is stopped, and that gives the hold behaviour.
module pfd_wave_out
    import pfd_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic port_bit,
    output logic wave_q,
    output logic pad_o
);

    pad_src_e pad_src;

    // Flip the wave on every overflow
    always_ff @(posedge clk) begin
        if (!rst_n)    wave_q <= 1'b0;
        else if (wrap) wave_q <= ~wave_q;
    end

    // Route the wave or a forced low to the pin
    always_comb begin
        pad_src = pick_pad_src(port_bit);
        pad_o   = (pad_src == PAD_FROM_WAVE) ? wave_q : 1'b0;
    end

endmodule

// File: rtl/pfd_timer.sv
// Module pfd_timer
// Preloadable up-counting timer with a divided square wave on a port pin.
// Assumes: cnt_en is the tick from an outer prescaler; the synchronous
// active-low reset leaves the timer stopped.
module pfd_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cnt_en,
    input  logic             pre_wr,
    input  logic [CNT_W-1:0] pre_data,
    input  logic             port_bit,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             pad_o
);

    logic [CNT_W-1:0] pre_q;
    logic [CNT_W-1:0] reload_val;
    logic             counting;
    logic             load_now;
    logic             wrap;
    logic             wave_level;

    // Qualify counting and the stopped-load path
    always_comb begin
        counting = run_en && cnt_en;
        load_now = pre_wr && !run_en;
    end

    pfd_preload #(.CNT_W(CNT_W)) u_preload (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre_wr     (pre_wr),
        .pre_data   (pre_data),
        .pre_q      (pre_q),
        .reload_val (reload_val)
    );

    pfd_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .counting   (counting),
        .load_now   (load_now),
        .load_val   (pre_data),
        .reload_val (reload_val),
        .count_o    (count_o),
        .wrap_o     (wrap),
        .ovf_o      (ovf_o)
    );

    pfd_wave_out u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .port_bit (port_bit),
        .wave_q   (wave_level),
        .pad_o    (pad_o)
    );

endmodule

// File: rtl/pfd_timer_chk.sv
// Module pfd_timer_chk
// Property checker bound to pfd_timer. It watches the ports and the
// internal wave level.
module pfd_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             cnt_en,
    input logic             pre_wr,
    input logic [CNT_W-1:0] pre_data,
    input logic             port_bit,
    input logic [CNT_W-1:0] count_o,
    input logic             ovf_o,
    input logic             pad_o,
    input logic             wave
);

    localparam logic [CNT_W-1:0] TOP = '1;

    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cnt_en && count_o != TOP) |=> count_o == $past(count_o) + 1'b1);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run_en && cnt_en) && !(pre_wr && !run_en)) |=> $stable(count_o));

    a_r3_pulse_on_top: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cnt_en && count_o == TOP) |=> ovf_o);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_en && cnt_en && count_o == TOP) |=> !ovf_o);

    a_r4_wave_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cnt_en && count_o == TOP) |=> wave != $past(wave));

    a_r4_wave_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_en && cnt_en && count_o == TOP) |=> $stable(wave));

    a_r5_pad_low: assert property (@(posedge clk) disable iff (!rst_n)
        !port_bit |-> !pad_o);

    a_r6_pad_wave: assert property (@(posedge clk) disable iff (!rst_n)
        (port_bit && run_en) |-> pad_o == wave);

    a_r7_pad_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && port_bit) |=> (port_bit && !run_en) |-> $stable(pad_o));

    a_r8_stopped_load: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_wr && !run_en) |=> count_o == $past(pre_data));

    a_r9_write_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_wr && run_en && cnt_en && count_o == TOP) |=> count_o == $past(pre_data));

endmodule

bind pfd_timer pfd_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .cnt_en   (cnt_en),
    .pre_wr   (pre_wr),
    .pre_data (pre_data),
    .port_bit (port_bit),
    .count_o  (count_o),
    .ovf_o    (ovf_o),
    .pad_o    (pad_o),
    .wave     (wave_level)
);

// File: tb/pfd_timer_bench.sv
module pfd_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam logic [W-1:0] TOP = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0, cnt_en = 1'b0, pre_wr = 1'b0, port_bit = 1'b0;
    logic [W-1:0] pre_data = '0;
    logic [W-1:0] count_o;
    logic ovf_o, pad_o;

    // wide variant
    logic w_run = 1'b0, w_wr = 1'b0;
    logic [15:0] w_data = '0;
    logic [15:0] w_count;
    logic w_ovf, w_pad;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [W-1:0] m_cnt = '0, m_pre = '0;
    logic m_pfd = 1'b0, m_ovf = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_timer #(.CNT_W(W)) u_pfd_timer (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_en(cnt_en),
        .pre_wr(pre_wr), .pre_data(pre_data), .port_bit(port_bit),
        .count_o(count_o), .ovf_o(ovf_o), .pad_o(pad_o)
    );

    pfd_timer #(.CNT_W(16)) u_pfd_timer_w16 (
        .clk(clk), .rst_n(rst_n), .run_en(w_run), .cnt_en(1'b1),
        .pre_wr(w_wr), .pre_data(w_data), .port_bit(1'b1),
        .count_o(w_count), .ovf_o(w_ovf), .pad_o(w_pad)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // expected next count from the requirements
    function automatic logic [W-1:0] next_cnt(input logic r, input logic c, input logic w,
                                              input logic [W-1:0] d, input logic [W-1:0] cur,
                                              input logic [W-1:0] pre);
        if (!r && w)   return d;
        if (r && c)    return (cur == TOP) ? (w ? d : pre) : cur + 1'b1;
        return cur;
    endfunction

    // one clock of stimulus, model update and comparison
    task automatic step(input logic r, input logic c, input logic w,
                        input logic [W-1:0] d, input logic pb);
        logic wrap;
        string ctag;
        run_en = r; cnt_en = c; pre_wr = w; pre_data = d; port_bit = pb;
        @(posedge clk);
        wrap  = r && c && (m_cnt == TOP);
        ctag  = (!r && w) ? "R8" : (wrap ? (w ? "R9" : "R3") : "R2");
        m_cnt = next_cnt(r, c, w, d, m_cnt, m_pre);
        m_ovf = wrap;
        if (wrap) m_pfd = ~m_pfd;
        if (w) m_pre = d;
        @(negedge clk);
        check(count_o == m_cnt, ctag, int'(count_o), int'(m_cnt));
        check(ovf_o == m_ovf, "R3", int'(ovf_o), int'(m_ovf));
        check(pad_o == (pb & m_pfd), pb ? (r ? "R6" : "R7") : "R5",
              int'(pad_o), int'(pb & m_pfd));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int edges;
        int last_edge;
        int gap;
        logic prev_pad;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        port_bit = 1'b1;
        #1;
        // R1 reset state
        check(count_o == 0, "R1", int'(count_o), 0);
        check(ovf_o == 0, "R1", int'(ovf_o), 0);
        check(pad_o == 0, "R1", int'(pad_o), 0);

        // R1: preload reset to 0, so first wrap lands on 0
        for (int i = 0; i < 256; i++) step(1, 1, 0, '0, 1);
        check(count_o == 0, "R1", int'(count_o), 0);

        // R8 load while stopped, R9 write on the overflow clock
        step(0, 0, 1, 8'hFF, 1);
        check(count_o == 8'hFF, "R8", int'(count_o), 255);
        step(1, 1, 1, 8'h10, 1);
        check(count_o == 8'h10, "R9", int'(count_o), 16);
        // R9 running write does not disturb the count
        step(1, 1, 1, 8'hF8, 1);
        check(count_o == 8'h11, "R9", int'(count_o), 17);

        // R4/R10: pad edge spacing equals 256 - N
        step(0, 0, 1, 8'hF0, 1);
        edges = 0; last_edge = 0; prev_pad = pad_o;
        for (int i = 1; i <= 100; i++) begin
            step(1, 1, 0, '0, 1);
            if (pad_o != prev_pad) begin
                if (edges > 0) begin
                    gap = i - last_edge;
                    check(gap == 16, "R4", gap, 16);
                end
                edges++;
                last_edge = i;
            end
            prev_pad = pad_o;
        end

        // N = all-ones: overflow on every tick
        step(0, 0, 1, 8'hFF, 1);
        for (int i = 0; i < 6; i++) step(1, 1, 0, '0, 1);
        check(ovf_o == 1, "R3", int'(ovf_o), 1);

        // R7 hold while stopped, R5 forced low
        for (int i = 0; i < 5; i++) step(0, 1, 0, '0, 1);
        for (int i = 0; i < 5; i++) step(1, 1, 0, '0, 0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic r, c, w, pb;
            logic [W-1:0] d;
            r  = ($urandom % 100) < 80;
            c  = ($urandom % 100) < 75;
            w  = ($urandom % 100) < 6;
            pb = ($urandom % 100) < 85;
            d  = 8'hE0 | W'($urandom % 32);
            step(r, c, w, d, pb);
        end

        // R10 wide variant: preload FFF0 gives overflow every 16 ticks
        w_wr = 1'b1; w_data = 16'hFFF0;
        @(negedge clk);
        w_wr = 1'b0; w_run = 1'b1;
        edges = 0; last_edge = 0;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (w_ovf) begin
                if (edges > 0) begin
                    gap = i - last_edge;
                    check(gap == 16, "R10", gap, 16);
                end
                edges++;
                last_edge = i;
            end
        end
        check(edges >= 3, "R10", edges, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule